// File: doc/BRIEF.md
# AXI Burst-to-Single-Beat Splitter

This block sits between a full AXI master port and a simplified slave. The slave takes only single-beat requests, is always ready, and answers every request after the same fixed number of cycles, in request order. The splitter breaks each read or write burst into separate beats and gives every beat its own address. A burst still moves at one beat per clock. On the slave side, the request fields that the simple slave should not have to decode are held at fixed values: length, last, ID, size, burst type and the attribute fields.

On the way back, the splitter rebuilds full AXI responses from the slave's single-beat replies. Each channel has a small pending FIFO that keeps the ID and the length of every accepted burst. Because the slave answers in order, a plain beat counter is enough to find the end of each burst, with no per-beat ID matching. For a write burst, the splitter returns one write response carrying the original ID and the most severe beat response. For a read burst, every data beat is forwarded in the cycle it arrives, carrying the original ID, and the last flag is raised on the final beat. The upstream response channels have no ready signal: the surrounding interconnect must accept every response in the cycle it is offered.

Top module: `axi_beat_splitter`

## Requirements
- R1: Every request toward the slave carries length 0, ID 0, size log2(data bytes), and burst, cache, protection and QoS fields of 0. Every write beat toward the slave carries last = 1.
- R2: A write request toward the slave (address valid and data valid, always raised together) appears exactly in a cycle where an upstream write-data beat is handshaken. Its data and byte strobes equal that beat's.
- R3: The first beat of a burst uses the burst's start address. With burst code 2'b01 (incrementing), each later beat uses the previous address rounded down to a data-word boundary plus the data width in bytes. With burst code 2'b00 (fixed), every beat repeats the start address.
- R4: A burst with length field L produces exactly L+1 slave requests. The end of a write burst is taken from the length field, since no upstream last flag is used.
- R5: A read burst issues one slave request on every cycle from the cycle after its address handshake until all its beats are out. Write-data ready is high on every cycle of an active write burst.
- R6: A new write (read) burst is accepted only when no write (read) burst is being split and that channel's pending FIFO holds fewer than DEPTH entries.
- R7: Each write burst produces exactly one response, in the same cycle as the slave's response to its last beat. That response carries the burst's original ID and the numerically largest response code among its beats.
- R8: Each slave read reply is forwarded in the same cycle with its data and response code, tagged with the burst's original ID. The last flag is set only on the final beat of each burst.
- R9: While reset is held low, both address-ready outputs are high and every valid output is low.
- R10: Reads and writes proceed independently and may overlap in time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| awValid | input | 1 | Upstream write address valid |
| awReady | output | 1 | Upstream write address ready |
| awId | input | IDW | Write burst ID |
| awAddr | input | AW | Write start address |
| awLen | input | LENW | Write beats minus one |
| awBurst | input | 2 | Write burst code (00 fixed, 01 incrementing) |
| wValid | input | 1 | Upstream write data valid |
| wReady | output | 1 | Upstream write data ready |
| wData | input | DW | Write data |
| wStrb | input | DW/8 | Write byte strobes |
| bValid | output | 1 | Merged write response valid |
| bId | output | IDW | Write response ID |
| bResp | output | 2 | Merged write response code |
| arValid | input | 1 | Upstream read address valid |
| arReady | output | 1 | Upstream read address ready |
| arId | input | IDW | Read burst ID |
| arAddr | input | AW | Read start address |
| arLen | input | LENW | Read beats minus one |
| arBurst | input | 2 | Read burst code |
| rValid | output | 1 | Read data valid |
| rId | output | IDW | Read data ID |
| rData | output | DW | Read data |
| rResp | output | 2 | Read response code |
| rLast | output | 1 | Final beat of a read burst |
| sAwValid | output | 1 | Slave write address valid |
| sAwAddr | output | AW | Slave write beat address |
| sAwLen | output | 8 | Slave write length (always 0) |
| sAwId | output | IDW | Slave write ID (always 0) |
| sAwSize | output | 3 | Slave write size (fixed) |
| sAwBurst | output | 2 | Slave write burst (always 0) |
| sAwCache | output | 4 | Slave write cache (always 0) |
| sAwProt | output | 3 | Slave write protection (always 0) |
| sAwQos | output | 4 | Slave write QoS (always 0) |
| sWValid | output | 1 | Slave write data valid |
| sWData | output | DW | Slave write data |
| sWStrb | output | DW/8 | Slave write strobes |
| sWLast | output | 1 | Slave write last (always 1) |
| sBValid | input | 1 | Slave write reply valid |
| sBResp | input | 2 | Slave write reply code |
| sArValid | output | 1 | Slave read address valid |
| sArAddr | output | AW | Slave read beat address |
| sArLen | output | 8 | Slave read length (always 0) |
| sArId | output | IDW | Slave read ID (always 0) |
| sArSize | output | 3 | Slave read size (fixed) |
| sArBurst | output | 2 | Slave read burst (always 0) |
| sArCache | output | 4 | Slave read cache (always 0) |
| sArProt | output | 3 | Slave read protection (always 0) |
| sArQos | output | 4 | Slave read QoS (always 0) |
| sRValid | input | 1 | Slave read reply valid |
| sRData | input | DW | Slave read reply data |
| sRResp | input | 2 | Slave read reply code |

## Verification
The assertions check the following on every cycle:
- No burst is accepted while its pending FIFO is full.
- No write response or last read beat appears without an outstanding burst.
- Each slave write request coincides with an upstream data handshake.
- Consecutive read beats step or hold their address according to the burst code.

Some behaviours only the bench's scenarios can show, because they depend on the slave's replies and on the upstream sequence:
- The restored IDs.
- Merging of the most severe write response.
- Placement of the last flag.
- Exact beat counts.
- Rounding of an unaligned start address.
- Ready-signal back-pressure while short bursts fill the FIFO.

// File: rtl/splitter_pkg.sv
package splitter_pkg;

  localparam logic [1:0] BURST_FIXED = 2'b00;
  localparam logic [1:0] BURST_INCR  = 2'b01;

  // strobes from control to datapath
  typedef struct packed {
    logic awTake;  // write burst accepted
    logic wStep;   // write beat issued to slave
    logic arTake;  // read burst accepted
    logic arStep;  // read beat issued to slave
    logic bDone;   // last write reply of a burst
    logic rDone;   // last read reply of a burst
  } split_strobe_t;

endpackage

// File: rtl/split_fifo.sv
module split_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wrPtr, rdPtr;
  logic [CW-1:0]    count;

  assign head = mem[rdPtr];
  assign full = (count == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == PW'(DEPTH - 1)) ? '0 : wrPtr + PW'(1);
      if (pop)  rdPtr <= (rdPtr == PW'(DEPTH - 1)) ? '0 : rdPtr + PW'(1);
      if (push && !pop)      count <= count + CW'(1);
      else if (pop && !push) count <= count - CW'(1);
    end
  end
endmodule

// File: rtl/split_ctrl.sv
module split_ctrl
  import splitter_pkg::*;
#(
  parameter int LENW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            awValid,
  input  logic            wValid,
  input  logic            arValid,
  input  logic            sBValid,
  input  logic            sRValid,
  input  logic            wFull,
  input  logic            rFull,
  input  logic [LENW-1:0] awLen,
  input  logic [LENW-1:0] arLen,
  input  logic [LENW-1:0] bHeadLen,
  input  logic [LENW-1:0] rHeadLen,
  output logic            awReady,
  output logic            wReady,
  output logic            arReady,
  output logic            sWrValid,
  output logic            sRdValid,
  output logic            bLast,
  output logic            rLast,
  output split_strobe_t   stb
);
  logic            wBusy, rBusy;
  logic [LENW-1:0] wLeft, rLeft, bCnt, rCnt;

  assign awReady  = !wBusy && !wFull;
  assign arReady  = !rBusy && !rFull;
  assign wReady   = wBusy;
  assign sWrValid = wBusy && wValid;
  assign sRdValid = rBusy;
  assign bLast    = (bCnt == bHeadLen);
  assign rLast    = (rCnt == rHeadLen);

  always_comb begin
    stb.awTake = awValid && awReady;
    stb.wStep  = sWrValid;
    stb.arTake = arValid && arReady;
    stb.arStep = rBusy;
    stb.bDone  = sBValid && bLast;
    stb.rDone  = sRValid && rLast;
  end

  // write burst beat counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wBusy <= 1'b0;
      wLeft <= '0;
    end else if (stb.awTake) begin
      wBusy <= 1'b1;
      wLeft <= awLen;
    end else if (stb.wStep) begin
      if (wLeft == '0) wBusy <= 1'b0;
      else             wLeft <= wLeft - LENW'(1);
    end
  end

  // read burst beat counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rBusy <= 1'b0;
      rLeft <= '0;
    end else if (stb.arTake) begin
      rBusy <= 1'b1;
      rLeft <= arLen;
    end else if (stb.arStep) begin
      if (rLeft == '0) rBusy <= 1'b0;
      else             rLeft <= rLeft - LENW'(1);
    end
  end

  // reply counters, in burst order
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bCnt <= '0;
      rCnt <= '0;
    end else begin
      if (sBValid) bCnt <= bLast ? '0 : bCnt + LENW'(1);
      if (sRValid) rCnt <= rLast ? '0 : rCnt + LENW'(1);
    end
  end
endmodule

// File: rtl/split_dpath.sv
module split_dpath
  import splitter_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int IDW   = 4,
  parameter int LENW  = 8,
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  split_strobe_t   stb,
  input  logic [IDW-1:0]  awId,
  input  logic [AW-1:0]   awAddr,
  input  logic [LENW-1:0] awLen,
  input  logic [1:0]      awBurst,
  input  logic [IDW-1:0]  arId,
  input  logic [AW-1:0]   arAddr,
  input  logic [LENW-1:0] arLen,
  input  logic [1:0]      arBurst,
  input  logic            sBValid,
  input  logic [1:0]      sBResp,
  output logic [AW-1:0]   sAwAddr,
  output logic [AW-1:0]   sArAddr,
  output logic            wFull,
  output logic            rFull,
  output logic [LENW-1:0] bHeadLen,
  output logic [LENW-1:0] rHeadLen,
  output logic [IDW-1:0]  bId,
  output logic [1:0]      bResp,
  output logic [IDW-1:0]  rId
);
  localparam int OFF = $clog2(DW / 8);
  localparam int HI  = AW - OFF;
  localparam int EW  = IDW + LENW;

  logic [AW-1:0] wAddr, rAddr;
  logic          wFixed, rFixed;
  logic [1:0]    bAcc;
  logic [EW-1:0] wHead, rHead;

  function automatic logic [AW-1:0] stepAddr(input logic [AW-1:0] a, input logic fixedB);
    stepAddr = fixedB ? a : {a[AW-1:OFF] + HI'(1), {OFF{1'b0}}};
  endfunction

  assign sAwAddr = wAddr;
  assign sArAddr = rAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wAddr  <= '0;
      wFixed <= 1'b0;
      rAddr  <= '0;
      rFixed <= 1'b0;
    end else begin
      if (stb.awTake) begin
        wAddr  <= awAddr;
        wFixed <= (awBurst == BURST_FIXED);
      end else if (stb.wStep) begin
        wAddr <= stepAddr(wAddr, wFixed);
      end
      if (stb.arTake) begin
        rAddr  <= arAddr;
        rFixed <= (arBurst == BURST_FIXED);
      end else if (stb.arStep) begin
        rAddr <= stepAddr(rAddr, rFixed);
      end
    end
  end

  split_fifo #(.WIDTH(EW), .DEPTH(DEPTH)) u_wq (
    .clk(clk), .rstN(rstN), .push(stb.awTake), .pushData({awId, awLen}),
    .pop(stb.bDone), .head(wHead), .full(wFull)
  );

  split_fifo #(.WIDTH(EW), .DEPTH(DEPTH)) u_rq (
    .clk(clk), .rstN(rstN), .push(stb.arTake), .pushData({arId, arLen}),
    .pop(stb.rDone), .head(rHead), .full(rFull)
  );

  assign bHeadLen = wHead[LENW-1:0];
  assign bId      = wHead[EW-1:LENW];
  assign rHeadLen = rHead[LENW-1:0];
  assign rId      = rHead[EW-1:LENW];

  // worst response seen so far in the current write burst
  assign bResp = (sBResp > bAcc) ? sBResp : bAcc;

  always_ff @(posedge clk) begin
    if (!rstN)        bAcc <= 2'b00;
    else if (sBValid) bAcc <= stb.bDone ? 2'b00 : bResp;
  end
endmodule

// File: rtl/axi_beat_splitter.sv
module axi_beat_splitter
  import splitter_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int IDW   = 4,
  parameter int LENW  = 8,
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              awValid,
  output logic              awReady,
  input  logic [IDW-1:0]    awId,
  input  logic [AW-1:0]     awAddr,
  input  logic [LENW-1:0]   awLen,
  input  logic [1:0]        awBurst,
  input  logic              wValid,
  output logic              wReady,
  input  logic [DW-1:0]     wData,
  input  logic [DW/8-1:0]   wStrb,
  output logic              bValid,
  output logic [IDW-1:0]    bId,
  output logic [1:0]        bResp,
  input  logic              arValid,
  output logic              arReady,
  input  logic [IDW-1:0]    arId,
  input  logic [AW-1:0]     arAddr,
  input  logic [LENW-1:0]   arLen,
  input  logic [1:0]        arBurst,
  output logic              rValid,
  output logic [IDW-1:0]    rId,
  output logic [DW-1:0]     rData,
  output logic [1:0]        rResp,
  output logic              rLast,
  output logic              sAwValid,
  output logic [AW-1:0]     sAwAddr,
  output logic [7:0]        sAwLen,
  output logic [IDW-1:0]    sAwId,
  output logic [2:0]        sAwSize,
  output logic [1:0]        sAwBurst,
  output logic [3:0]        sAwCache,
  output logic [2:0]        sAwProt,
  output logic [3:0]        sAwQos,
  output logic              sWValid,
  output logic [DW-1:0]     sWData,
  output logic [DW/8-1:0]   sWStrb,
  output logic              sWLast,
  input  logic              sBValid,
  input  logic [1:0]        sBResp,
  output logic              sArValid,
  output logic [AW-1:0]     sArAddr,
  output logic [7:0]        sArLen,
  output logic [IDW-1:0]    sArId,
  output logic [2:0]        sArSize,
  output logic [1:0]        sArBurst,
  output logic [3:0]        sArCache,
  output logic [2:0]        sArProt,
  output logic [3:0]        sArQos,
  input  logic              sRValid,
  input  logic [DW-1:0]     sRData,
  input  logic [1:0]        sRResp
);
  localparam logic [2:0] BEAT_SIZE = 3'($clog2(DW / 8));

  split_strobe_t   stb;
  logic            wFull, rFull, bLastHit, rLastHit, sWrValid;
  logic [LENW-1:0] bHeadLen, rHeadLen;

  split_ctrl #(.LENW(LENW)) u_ctrl (
    .clk(clk), .rstN(rstN), .awValid(awValid), .wValid(wValid), .arValid(arValid),
    .sBValid(sBValid), .sRValid(sRValid), .wFull(wFull), .rFull(rFull),
    .awLen(awLen), .arLen(arLen), .bHeadLen(bHeadLen), .rHeadLen(rHeadLen),
    .awReady(awReady), .wReady(wReady), .arReady(arReady),
    .sWrValid(sWrValid), .sRdValid(sArValid), .bLast(bLastHit), .rLast(rLastHit),
    .stb(stb)
  );

  split_dpath #(.AW(AW), .DW(DW), .IDW(IDW), .LENW(LENW), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .awId(awId), .awAddr(awAddr), .awLen(awLen), .awBurst(awBurst),
    .arId(arId), .arAddr(arAddr), .arLen(arLen), .arBurst(arBurst),
    .sBValid(sBValid), .sBResp(sBResp),
    .sAwAddr(sAwAddr), .sArAddr(sArAddr), .wFull(wFull), .rFull(rFull),
    .bHeadLen(bHeadLen), .rHeadLen(rHeadLen),
    .bId(bId), .bResp(bResp), .rId(rId)
  );

  // single-beat request fields
  assign sAwValid = sWrValid;
  assign sWValid  = sWrValid;
  assign sWData   = wData;
  assign sWStrb   = wStrb;
  assign sWLast   = 1'b1;
  assign sAwLen   = '0;
  assign sAwId    = '0;
  assign sAwSize  = BEAT_SIZE;
  assign sAwBurst = '0;
  assign sAwCache = '0;
  assign sAwProt  = '0;
  assign sAwQos   = '0;
  assign sArLen   = '0;
  assign sArId    = '0;
  assign sArSize  = BEAT_SIZE;
  assign sArBurst = '0;
  assign sArCache = '0;
  assign sArProt  = '0;
  assign sArQos   = '0;

  // rebuilt responses
  assign bValid = stb.bDone;
  assign rValid = sRValid;
  assign rData  = sRData;
  assign rResp  = sRResp;
  assign rLast  = sRValid && rLastHit;
endmodule

// File: rtl/axi_beat_splitter_chk.sv
module axi_beat_splitter_chk #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input logic          clk,
  input logic          rstN,
  input logic          awValid,
  input logic          awReady,
  input logic          arValid,
  input logic          arReady,
  input logic [1:0]    arBurst,
  input logic          wValid,
  input logic          wReady,
  input logic          bValid,
  input logic          rValid,
  input logic          rLast,
  input logic          sAwValid,
  input logic          sWValid,
  input logic          sArValid,
  input logic [AW-1:0] sArAddr
);
  localparam int OFF = $clog2(DW / 8);
  localparam int HI  = AW - OFF;

  int   wOut, rOut;
  logic ckFixed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wOut    <= 0;
      rOut    <= 0;
      ckFixed <= 1'b0;
    end else begin
      wOut <= wOut + int'(awValid && awReady) - int'(bValid);
      rOut <= rOut + int'(arValid && arReady) - int'(rValid && rLast);
      if (arValid && arReady) ckFixed <= (arBurst == 2'b00);
    end
  end

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    (awValid && awReady) |-> (wOut < DEPTH));

  p_rd_no_overflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    (arValid && arReady) |-> (rOut < DEPTH));

  p_bresp_owed_r7: assert property (@(posedge clk) disable iff (!rstN)
    bValid |-> (wOut > 0));

  p_rlast_owed_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rValid && rLast) |-> (rOut > 0));

  p_beat_gated_r2: assert property (@(posedge clk) disable iff (!rstN)
    sAwValid |-> (wValid && wReady && sWValid));

  p_incr_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (sArValid && $past(sArValid) && !ckFixed) |->
      (sArAddr == {$past(sArAddr[AW-1:OFF]) + HI'(1), {OFF{1'b0}}}));

  p_fixed_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (sArValid && $past(sArValid) && ckFixed) |-> $stable(sArAddr));
endmodule

bind axi_beat_splitter axi_beat_splitter_chk #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .awValid(awValid), .awReady(awReady),
  .arValid(arValid), .arReady(arReady), .arBurst(arBurst),
  .wValid(wValid), .wReady(wReady), .bValid(bValid), .rValid(rValid), .rLast(rLast),
  .sAwValid(sAwValid), .sWValid(sWValid), .sArValid(sArValid), .sArAddr(sArAddr)
);

// File: tb/sim_axi_beat_splitter.sv
module sim_axi_beat_splitter;
  localparam int AW = 16, DW = 32, IDW = 4, LENW = 4, DEPTH = 2, LAT = 3;

  logic clk = 1'b0, rstN = 1'b0;
  always #5 clk = ~clk;

  logic awValid = 0, wValid = 0, arValid = 0;
  logic [IDW-1:0] awId = 0, arId = 0;
  logic [AW-1:0] awAddr = 0, arAddr = 0;
  logic [LENW-1:0] awLen = 0, arLen = 0;
  logic [1:0] awBurst = 0, arBurst = 0;
  logic [DW-1:0] wData = 0;
  logic [3:0] wStrb = 0;
  logic awReady, wReady, bValid, arReady, rValid, rLast;
  logic [IDW-1:0] bId, rId, sAwId, sArId;
  logic [1:0] bResp, rResp, sAwBurst, sArBurst;
  logic [DW-1:0] rData, sWData, sRData;
  logic sAwValid, sWValid, sWLast, sArValid;
  logic [AW-1:0] sAwAddr, sArAddr;
  logic [7:0] sAwLen, sArLen;
  logic [2:0] sAwSize, sArSize, sAwProt, sArProt;
  logic [3:0] sAwCache, sArCache, sAwQos, sArQos, sWStrb;
  logic sBValid, sRValid;
  logic [1:0] sBResp, sRResp;

  axi_beat_splitter #(.AW(AW), .DW(DW), .IDW(IDW), .LENW(LENW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN),
    .awValid(awValid), .awReady(awReady), .awId(awId), .awAddr(awAddr), .awLen(awLen), .awBurst(awBurst),
    .wValid(wValid), .wReady(wReady), .wData(wData), .wStrb(wStrb),
    .bValid(bValid), .bId(bId), .bResp(bResp),
    .arValid(arValid), .arReady(arReady), .arId(arId), .arAddr(arAddr), .arLen(arLen), .arBurst(arBurst),
    .rValid(rValid), .rId(rId), .rData(rData), .rResp(rResp), .rLast(rLast),
    .sAwValid(sAwValid), .sAwAddr(sAwAddr), .sAwLen(sAwLen), .sAwId(sAwId), .sAwSize(sAwSize),
    .sAwBurst(sAwBurst), .sAwCache(sAwCache), .sAwProt(sAwProt), .sAwQos(sAwQos),
    .sWValid(sWValid), .sWData(sWData), .sWStrb(sWStrb), .sWLast(sWLast),
    .sBValid(sBValid), .sBResp(sBResp),
    .sArValid(sArValid), .sArAddr(sArAddr), .sArLen(sArLen), .sArId(sArId), .sArSize(sArSize),
    .sArBurst(sArBurst), .sArCache(sArCache), .sArProt(sArProt), .sArQos(sArQos),
    .sRValid(sRValid), .sRData(sRData), .sRResp(sRResp)
  );

  // ---------- slave model: fixed latency, in order ----------
  function automatic logic [1:0] errOf(input logic [AW-1:0] a);
    return (a[7:4] == 4'hF) ? 2'b10 : 2'b00;
  endfunction
  function automatic logic [DW-1:0] dataOf(input logic [AW-1:0] a);
    return {~a, a};
  endfunction

  logic          bPv [LAT];
  logic [1:0]    bPr [LAT];
  logic          rPv [LAT];
  logic [AW-1:0] rPa [LAT];

  always @(posedge clk) begin
    for (int i = LAT - 1; i > 0; i--) begin
      bPv[i] <= bPv[i-1]; bPr[i] <= bPr[i-1];
      rPv[i] <= rPv[i-1]; rPa[i] <= rPa[i-1];
    end
    bPv[0] <= rstN && sAwValid; bPr[0] <= errOf(sAwAddr);
    rPv[0] <= rstN && sArValid; rPa[0] <= sArAddr;
  end
  assign sBValid = bPv[LAT-1] === 1'b1;
  assign sBResp  = bPr[LAT-1];
  assign sRValid = rPv[LAT-1] === 1'b1;
  assign sRData  = dataOf(rPa[LAT-1]);
  assign sRResp  = errOf(rPa[LAT-1]);

  // ---------- reference model ----------
  typedef struct { logic [IDW-1:0] id; logic [DW-1:0] d; logic [1:0] r; logic last; } rexp_t;
  typedef struct { logic [IDW-1:0] id; logic [1:0] r; } bexp_t;
  logic [AW-1:0] expAw[$], expAr[$];
  bexp_t expB[$];
  rexp_t expR[$];
  bit wBusyM = 0, rBusyM = 0, monOn = 0;
  int wLeftM = 0, rLeftM = 0, wOutM = 0, rOutM = 0;
  int nChk = 0, nBad = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] a, input bit fx);
    return fx ? a : ((a & ~AW'(3)) + AW'(4));
  endfunction

  always @(negedge clk) begin
    if (monOn) begin
      chk(awReady == (!wBusyM && wOutM < DEPTH), "R6 awReady", 64'(awReady), 64'(!wBusyM && wOutM < DEPTH));
      chk(arReady == (!rBusyM && rOutM < DEPTH), "R6 arReady", 64'(arReady), 64'(!rBusyM && rOutM < DEPTH));
      chk(wReady == wBusyM, "R5 wReady", 64'(wReady), 64'(wBusyM));
      chk(sArValid == rBusyM, "R5 read beat per cycle", 64'(sArValid), 64'(rBusyM));
      chk(sAwValid == (wBusyM && wValid), "R2 write beat gating", 64'(sAwValid), 64'(wBusyM && wValid));
      chk(sWValid == sAwValid, "R2 addr/data valid pair", 64'(sWValid), 64'(sAwValid));
      if (sAwValid) begin
        logic [AW-1:0] ea;
        ea = (expAw.size() > 0) ? expAw.pop_front() : 'x;
        chk(sAwAddr === ea, "R3 write beat address", 64'(sAwAddr), 64'(ea));
        chk(sWData == wData && sWStrb == wStrb, "R2 write data", 64'(sWData), 64'(wData));
        chk(sAwLen == 0 && sAwId == 0 && sAwSize == 3'd2 && sAwBurst == 0 && sAwCache == 0
            && sAwProt == 0 && sAwQos == 0 && sWLast == 1, "R1 write fixed fields",
            64'({sAwLen, sAwSize, sAwBurst, sWLast}), 64'({8'd0, 3'd2, 2'd0, 1'b1}));
      end
      if (sArValid) begin
        logic [AW-1:0] ea;
        ea = (expAr.size() > 0) ? expAr.pop_front() : 'x;
        chk(sArAddr === ea, "R3 read beat address", 64'(sArAddr), 64'(ea));
        chk(sArLen == 0 && sArId == 0 && sArSize == 3'd2 && sArBurst == 0 && sArCache == 0
            && sArProt == 0 && sArQos == 0, "R1 read fixed fields",
            64'({sArLen, sArSize, sArBurst}), 64'({8'd0, 3'd2, 2'd0}));
      end
      if (bValid) begin
        if (expB.size() == 0) chk(0, "R7 unexpected write response", 1, 0);
        else begin
          bexp_t e;
          e = expB.pop_front();
          chk(bId == e.id, "R7 bId", 64'(bId), 64'(e.id));
          chk(bResp == e.r, "R7 merged bResp", 64'(bResp), 64'(e.r));
        end
      end
      if (rValid) begin
        if (expR.size() == 0) chk(0, "R8 unexpected read beat", 1, 0);
        else begin
          rexp_t e;
          e = expR.pop_front();
          chk(rId == e.id, "R8 rId", 64'(rId), 64'(e.id));
          chk(rData == e.d && rResp == e.r, "R8 rData/rResp", 64'({rResp, rData}), 64'({e.r, e.d}));
          chk(rLast == e.last, "R8 rLast", 64'(rLast), 64'(e.last));
        end
      end
      // state advance for the coming edge
      if (awValid && awReady) begin
        logic [AW-1:0] a; logic [1:0] worst;
        a = awAddr; worst = 0;
        for (int i = 0; i <= int'(awLen); i++) begin
          expAw.push_back(a);
          if (errOf(a) > worst) worst = errOf(a);
          a = nxt(a, awBurst == 2'b00);
        end
        expB.push_back('{awId, worst});
        wBusyM = 1; wLeftM = int'(awLen) + 1; wOutM++;
      end
      if (wValid && wReady) begin
        wLeftM--;
        if (wLeftM == 0) wBusyM = 0;
      end
      if (bValid) wOutM--;
      if (arValid && arReady) begin
        logic [AW-1:0] a;
        a = arAddr;
        for (int i = 0; i <= int'(arLen); i++) begin
          expAr.push_back(a);
          expR.push_back('{arId, dataOf(a), errOf(a), i == int'(arLen)});
          a = nxt(a, arBurst == 2'b00);
        end
        rBusyM = 1; rLeftM = int'(arLen) + 1; rOutM++;
      end
      if (sArValid) begin
        rLeftM--;
        if (rLeftM == 0) rBusyM = 0;
      end
      if (rValid && rLast) rOutM--;
    end
  end

  // ---------- stimulus ----------
  task automatic doWrite(input logic [IDW-1:0] id, input logic [AW-1:0] a,
                         input logic [LENW-1:0] len, input logic [1:0] bt, input int gap);
    @(negedge clk);
    awValid = 1; awId = id; awAddr = a; awLen = len; awBurst = bt;
    while (!awReady) @(negedge clk);
    @(negedge clk);
    awValid = 0;
    for (int i = 0; i <= int'(len); i++) begin
      if (gap > 0 && i % 2 == 1) begin
        wValid = 0;
        repeat (gap) @(negedge clk);
      end
      wValid = 1; wData = {id, 12'(i), a}; wStrb = 4'(i + 5);
      @(negedge clk);
    end
    wValid = 0;
  endtask

  task automatic doRead(input logic [IDW-1:0] id, input logic [AW-1:0] a,
                        input logic [LENW-1:0] len, input logic [1:0] bt);
    @(negedge clk);
    arValid = 1; arId = id; arAddr = a; arLen = len; arBurst = bt;
    while (!arReady) @(negedge clk);
    @(negedge clk);
    arValid = 0;
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      nBad++;
      $display("FAIL R10 watchdog: actual %0d cycles expected under 20000", cyc);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: state while reset is held
    chk(awReady && arReady, "R9 readies in reset", 64'({awReady, arReady}), 64'(3));
    chk(!bValid && !rValid && !sAwValid && !sArValid && !wReady, "R9 valids in reset",
        64'({bValid, rValid, sAwValid, sArValid, wReady}), 0);
    rstN = 1;
    monOn = 1;
    // writes: single beat, incrementing with gaps, fixed, error merge
    doWrite(4'h1, 16'h0010, 4'd0, 2'b01, 0);
    doWrite(4'h2, 16'h0020, 4'd3, 2'b01, 1);
    doWrite(4'h3, 16'h0044, 4'd2, 2'b00, 0);
    doWrite(4'h4, 16'h00E8, 4'd3, 2'b01, 0);   // R7: third beat hits error region
    // reads: long incrementing, fixed in error region, unaligned start (R3, R4, R5)
    doRead(4'h5, 16'h0100, 4'd7, 2'b01);
    doRead(4'h6, 16'h00F0, 4'd3, 2'b00);
    doRead(4'h7, 16'h0102, 4'd2, 2'b01);
    // R6 + R10: short bursts on both channels at once fill the pending FIFOs
    fork
      for (int i = 0; i < 5; i++) doRead(4'(8 + i), 16'(16'h0200 + i * 4), 4'd0, 2'b01);
      for (int i = 0; i < 5; i++) doWrite(4'(i), 16'(16'h0300 + i * 8), 4'd0, 2'b01, 0);
    join
    doWrite(4'hA, 16'h0400, 4'd15, 2'b01, 0);  // R4: maximum length
    wait (!wBusyM && !rBusyM && wOutM == 0 && rOutM == 0);
    repeat (LAT + 3) @(negedge clk);
    chk(expB.size() == 0 && expR.size() == 0, "R7 R8 every burst answered",
        64'(expB.size() + expR.size()), 0);
    chk(expAw.size() == 0 && expAr.size() == 0, "R4 all beats issued",
        64'(expAw.size() + expAr.size()), 0);
    finishRun();
  end
endmodule